// File: doc/BRIEF.md
# PCI configuration address translator

This block is the host-side port through which a processor reaches PCI configuration space. It has two 4 KiB windows on a simple memory-mapped slave bus. A write to the index window stores a 32-bit configuration index. A read or write to the data window becomes one configuration transaction on a downstream request port, which answers with a valid/ready handshake.

The stored index can take one of three forms, and each is rewritten into a standard bus/device/function/register address:
- **Escape form:** passed through.
- **Type-1 form:** taken with its low bits replaced.
- **One-hot form:** the device is named by a single set bit in the upper index bits. The lowest such bit becomes an encoded slot number.

The low bits of the data-window offset are merged into the address in every form. Data lanes are little-endian, and the access size reaches the downstream side as byte enables.

The block also holds the interrupt swizzle. It folds the four interrupt pins of every device on the bus onto four controller lines. Those lines feed controller inputs 0x1B to 0x1E, in that order.

Top module: `cfgx_top`

## Requirements
- R1: After reset the stored index is zero, `s_ack` is low and `d_valid` is low.
- R2: An index-window write updates only the index bytes selected by its byte enables. An index-window read returns the whole stored index on `s_rdata`.
- R3: When index bit 31 is 1, `d_addr` equals the index ORed with data-window offset bits [1:0].
- R4: When index bit 31 is 0 and index bit 0 is 1, `d_addr` is the index with bits [2:0] replaced by offset bits [2:0].
- R5: When index bits 31 and 0 are both 0, the lowest set bit among index bits [31:11] gives slot number s. `d_addr` is then built as follows:
  - bits [15:11] hold s, and bits [31:16] are 0;
  - bits [10:8] copy index bits [10:8];
  - bits [7:3] copy index bits [7:3];
  - bits [2:0] copy offset bits [2:0].
- R6: In the one-hot form, when index bits [31:11] are all 0, `d_addr` bits [31:11] are all 1. The lower bits follow R5.
- R7: `s_size` gives the byte enables on `d_be`, where bit k enables byte lane k (data bits 8k+7..8k), and offset bits [1:0] give the lane:
  - value 0 (1 byte) enables lane offset[1:0];
  - value 1 (2 bytes) enables lanes 1:0, or lanes 3:2 when offset bit 1 is 1;
  - values 2 and 3 (4 bytes) enable all four lanes.
- R8: Each data-window access issues exactly one request, with `d_we` set as `s_we` and `d_wdata` equal to `s_wdata`. `d_valid` and `d_addr` hold steady until `d_ready`. `s_ack` pulses for one cycle, the cycle after the handshake, and for a read carries `d_rdata` on `s_rdata`.
- R9: Interrupt pin p (0 to 3) of device d sits on input bit 4d+p of `irq_pin`. It drives output line (p + d) mod 4. Each `irq_line` bit is the OR of all pins mapped to it.
- R10: An index-window access never raises `d_valid`. It is acknowledged on the second clock edge after `s_req` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_req | input | 1 | Slave access request, held until `s_ack` |
| s_we | input | 1 | 1 = write, 0 = read |
| s_addr | input | 13 | Bit 12 selects the data window (1) or the index window (0); bits 11:0 are the offset |
| s_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| s_wdata | input | 32 | Lane-aligned write data |
| s_ack | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Lane-aligned read data, valid with `s_ack` |
| d_valid | output | 1 | Downstream configuration request valid |
| d_we | output | 1 | Downstream request is a write |
| d_addr | output | 32 | Translated configuration address |
| d_be | output | 4 | Byte enables of the request |
| d_wdata | output | 32 | Write data of the request |
| d_ready | input | 1 | Downstream accepts and completes the request |
| d_rdata | input | 32 | Downstream read data, valid with `d_ready` |
| irq_pin | input | 128 | Interrupt pins, bit 4d+p = pin p of device d |
| irq_line | output | 4 | Swizzled lines to controller inputs 0x1B..0x1E |

## Verification
The interrupt swizzle is combinational and runs every cycle. It can therefore change in the same cycle that a configuration transaction is waiting on the downstream handshake. The bench drives random pin patterns from a separate process while data-window accesses stall for random lengths of time. Each `irq_line` value is judged against a bench model of the modulo-4 mapping. Every request is judged, at its handshake, against an independently computed address, byte-enable pattern and data.

// File: rtl/cfgx_pkg.sv
// Package cfgx_pkg
// Shared widths, state and index-format types of the configuration
// address translator. Assumes a 32-bit configuration index and data path.
package cfgx_pkg;
    localparam int unsigned CFG_W        = 32;
    localparam int unsigned LANES        = CFG_W / 8;
    localparam int unsigned IRQ_LINES    = 4;
    localparam logic [7:0]  IRQ_TAG_BASE = 8'h1B;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } cfgx_state_e;

    typedef enum logic [1:0] {
        FMT_ONEHOT = 2'd0,
        FMT_TYPE1  = 2'd1,
        FMT_ESCAPE = 2'd2
    } cfgx_fmt_e;
endpackage

// File: rtl/cfgx_xlat.sv
// Module cfgx_xlat
// Combinational rewrite of the stored configuration index into a
// bus/device/function/register address. It merges the low offset bits
// of the data-window access. Assumes index bit 31 marks the escape form
// and bit 0 the type-1 form; otherwise the index is one-hot in its
// upper bits.
module cfgx_xlat
    import cfgx_pkg::*;
#(
    parameter int unsigned ADDR_W   = CFG_W,
    parameter int unsigned SLOT_LSB = 11
) (
    input  logic [ADDR_W-1:0] idx,
    input  logic [2:0]        off,
    output logic [ADDR_W-1:0] xaddr,
    output cfgx_fmt_e         fmt
);
    localparam int unsigned SLOT_W = $clog2(ADDR_W);

    logic              slot_found;
    logic [SLOT_W-1:0] slot_num;
    logic [ADDR_W-1:0] slot_field;
    logic [ADDR_W-1:0] onehot_addr;

    // Find the lowest set bit of the device-select field (scan from the top).
    always_comb begin
        slot_found = 1'b0;
        slot_num   = '0;
        for (int b = ADDR_W - 1; b >= int'(SLOT_LSB); b--) begin
            if (idx[b]) begin
                slot_found = 1'b1;
                slot_num   = SLOT_W'(b);
            end
        end
    end

    // Place the slot number; an empty select field gives all ones from SLOT_LSB up.
    always_comb begin
        if (slot_found)
            slot_field = {{(ADDR_W-SLOT_W){1'b0}}, slot_num} << SLOT_LSB;
        else
            slot_field = {ADDR_W{1'b1}} << SLOT_LSB;
    end

    // Function and register bits come from the index, byte bits from the offset.
    assign onehot_addr = slot_field |
                         {{(ADDR_W-SLOT_LSB){1'b0}}, idx[SLOT_LSB-1:3], off};

    // Select the format and the resulting address.
    always_comb begin
        if (idx[ADDR_W-1]) begin
            fmt   = FMT_ESCAPE;
            xaddr = idx | {{(ADDR_W-2){1'b0}}, off[1:0]};
        end else if (idx[0]) begin
            fmt   = FMT_TYPE1;
            xaddr = {idx[ADDR_W-1:3], off};
        end else begin
            fmt   = FMT_ONEHOT;
            xaddr = onehot_addr;
        end
    end
endmodule

// File: rtl/cfgx_swizzle.sv
// Module cfgx_swizzle
// Interrupt swizzle: pin p of device d drives line (p + d) mod IRQ_LINES.
// Combinational. Assumes IRQ_LINES pins per device, packed with device d
// at bits [IRQ_LINES*d +: IRQ_LINES]. The clock and reset serve only the
// embedded check.
module cfgx_swizzle
    import cfgx_pkg::*;
#(
    parameter int unsigned NUM_DEV = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_DEV*IRQ_LINES-1:0] pin,
    output logic [IRQ_LINES-1:0]         line
);
    for (genvar l = 0; l < IRQ_LINES; l++) begin : g_line
        // OR every pin whose rotated position lands on line l.
        always_comb begin
            line[l] = 1'b0;
            for (int d = 0; d < int'(NUM_DEV); d++)
                for (int p = 0; p < int'(IRQ_LINES); p++)
                    if (((p + d) % int'(IRQ_LINES)) == l)
                        line[l] = line[l] | pin[d*IRQ_LINES + p];
        end
    end

    // R9
    idle_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin == '0) |-> (line == '0));
endmodule

// File: rtl/cfgx_ctrl.sv
// Module cfgx_ctrl
// Slave-side sequencer. It holds the index register, decodes the two
// windows and forms byte enables. It launches one downstream request per
// data-window access and returns the completion. Assumes the master
// holds s_req until s_ack and drops it in the cycle s_ack is seen.
module cfgx_ctrl
    import cfgx_pkg::*;
#(
    parameter int unsigned WIN_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req,
    input  logic              s_we,
    input  logic              s_win_data,
    input  logic [1:0]        s_lane,
    input  logic [1:0]        s_size,
    input  logic [CFG_W-1:0]  s_wdata,
    output logic              s_ack,
    output logic [CFG_W-1:0]  s_rdata,
    input  logic [CFG_W-1:0]  xaddr,
    output logic [CFG_W-1:0]  idx,
    output logic              d_valid,
    output logic              d_we,
    output logic [CFG_W-1:0]  d_addr,
    output logic [LANES-1:0]  d_be,
    output logic [CFG_W-1:0]  d_wdata,
    input  logic              d_ready,
    input  logic [CFG_W-1:0]  d_rdata
);
    cfgx_state_e      state;
    logic [LANES-1:0] be;
    logic             accept;

    assign accept  = (state == ST_IDLE) && s_req;
    assign s_ack   = (state == ST_DONE);
    assign d_valid = (state == ST_BUSY);

    // Byte enables from access size and lane offset (little-endian).
    always_comb begin
        case (s_size)
            2'd0:    be = LANES'(1) << s_lane;
            2'd1:    be = s_lane[1] ? 4'b1100 : 4'b0011;
            default: be = '1;
        endcase
    end

    // Sequencer: idle, downstream request in flight, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (s_req) state <= s_win_data ? ST_BUSY : ST_DONE;
                ST_BUSY: if (d_ready) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Index register: byte-enabled writes through the index window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (accept && !s_win_data && s_we) begin
            for (int k = 0; k < int'(LANES); k++)
                if (be[k]) idx[8*k +: 8] <= s_wdata[8*k +: 8];
        end
    end

    // Request fields captured when a data-window access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_we    <= 1'b0;
            d_addr  <= '0;
            d_be    <= '0;
            d_wdata <= '0;
        end else if (accept && s_win_data) begin
            d_we    <= s_we;
            d_addr  <= xaddr;
            d_be    <= be;
            d_wdata <= s_wdata;
        end
    end

    // Read data: the index for the index window, the downstream data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s_rdata <= '0;
        else if (accept && !s_win_data)
            s_rdata <= idx;
        else if (d_valid && d_ready)
            s_rdata <= d_rdata;
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_addr) && $stable(d_be)));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |=> !s_ack);

    // R8
    ack_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_ready) |=> (s_ack && !d_valid));

    // R10
    index_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !s_win_data) |=> (!d_valid && s_ack));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!s_ack && !d_valid && idx == '0));
endmodule

// File: rtl/cfgx_top.sv
// Module cfgx_top
// Configuration access port: index and data windows on a slave bus,
// index translation, downstream request port and interrupt swizzle.
// Assumes the window select sits at s_addr[WIN_BITS]; the offset bits
// above bit 2 do not affect the translation.
module cfgx_top
    import cfgx_pkg::*;
#(
    parameter int unsigned WIN_BITS = 12,
    parameter int unsigned NUM_DEV  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s_req,
    input  logic                         s_we,
    input  logic [WIN_BITS:0]            s_addr,
    input  logic [1:0]                   s_size,
    input  logic [CFG_W-1:0]             s_wdata,
    output logic                         s_ack,
    output logic [CFG_W-1:0]             s_rdata,
    output logic                         d_valid,
    output logic                         d_we,
    output logic [CFG_W-1:0]             d_addr,
    output logic [LANES-1:0]             d_be,
    output logic [CFG_W-1:0]             d_wdata,
    input  logic                         d_ready,
    input  logic [CFG_W-1:0]             d_rdata,
    input  logic [NUM_DEV*IRQ_LINES-1:0] irq_pin,
    output logic [IRQ_LINES-1:0]         irq_line
);
    logic [CFG_W-1:0] idx;
    logic [CFG_W-1:0] xaddr;
    cfgx_fmt_e        fmt;
    logic             unused_off_bits;

    assign unused_off_bits = ^{s_addr[WIN_BITS-1:3], fmt};

    cfgx_ctrl #(.WIN_BITS(WIN_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_req     (s_req),
        .s_we      (s_we),
        .s_win_data(s_addr[WIN_BITS]),
        .s_lane    (s_addr[1:0]),
        .s_size    (s_size),
        .s_wdata   (s_wdata),
        .s_ack     (s_ack),
        .s_rdata   (s_rdata),
        .xaddr     (xaddr),
        .idx       (idx),
        .d_valid   (d_valid),
        .d_we      (d_we),
        .d_addr    (d_addr),
        .d_be      (d_be),
        .d_wdata   (d_wdata),
        .d_ready   (d_ready),
        .d_rdata   (d_rdata)
    );

    cfgx_xlat #(.ADDR_W(CFG_W), .SLOT_LSB(11)) u_xlat (
        .idx  (idx),
        .off  (s_addr[2:0]),
        .xaddr(xaddr),
        .fmt  (fmt)
    );

    cfgx_swizzle #(.NUM_DEV(NUM_DEV)) u_swz (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (irq_pin),
        .line (irq_line)
    );

    // R3
    escape_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && idx[31]) |-> (d_addr[31:2] == idx[31:2]));

    // R4
    type1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !idx[31] && idx[0]) |-> (d_addr[31:3] == idx[31:3]));

    // R6
    empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !idx[31] && !idx[0] && idx[31:11] == '0) |-> (&d_addr[31:11]));

    // R5
    onehot_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !idx[31] && !idx[0]) |-> (d_addr[10:3] == idx[10:3]));
endmodule

// File: tb/cfgx_top_bench.sv
// Bench for cfgx_top: fixed-seed random accesses in all three index
// forms plus directed corners, against bench models of the translation,
// byte enables and interrupt swizzle.
module cfgx_top_bench;
    localparam int NDEV = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_req = 1'b0;
    logic              s_we = 1'b0;
    logic [12:0]       s_addr = '0;
    logic [1:0]        s_size = '0;
    logic [31:0]       s_wdata = '0;
    logic              s_ack;
    logic [31:0]       s_rdata;
    logic              d_valid;
    logic              d_we;
    logic [31:0]       d_addr;
    logic [3:0]        d_be;
    logic [31:0]       d_wdata;
    logic              d_ready = 1'b0;
    logic [31:0]       d_rdata = '0;
    logic [NDEV*4-1:0] irq_pin = '0;
    logic [3:0]        irq_line;

    int checks = 0;
    int errors = 0;
    int hs_count = 0;
    int wait_left = 0;
    bit done = 0;
    logic        cap_we;
    logic [31:0] cap_addr, cap_wdata;
    logic [3:0]  cap_be;
    logic [31:0] rd_word;

    always #10 clk = ~clk;

    cfgx_top u_cfgx_top (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_size(s_size), .s_wdata(s_wdata), .s_ack(s_ack), .s_rdata(s_rdata),
        .d_valid(d_valid), .d_we(d_we), .d_addr(d_addr), .d_be(d_be),
        .d_wdata(d_wdata), .d_ready(d_ready), .d_rdata(d_rdata),
        .irq_pin(irq_pin), .irq_line(irq_line)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_addr(input logic [31:0] idx, input logic [11:0] off);
        logic [31:0] slot;
        if (idx[31]) return idx | {30'd0, off[1:0]};
        if (idx[0]) return (idx & ~32'd7) | {29'd0, off[2:0]};
        slot = 32'hFFFF_FFFF;
        for (int b = 11; b < 32; b++) if (idx[b]) begin slot = b; break; end
        return (idx & 32'hF8) | {29'd0, off[2:0]} | (((idx >> 8) & 32'd7) << 8) | (slot << 11);
    endfunction

    function automatic logic [3:0] model_be(input logic [1:0] size, input logic [1:0] lane);
        if (size == 2'd0) return 4'(1 << lane);
        if (size == 2'd1) return lane[1] ? 4'hC : 4'h3;
        return 4'hF;
    endfunction

    function automatic logic [3:0] model_irq(input logic [NDEV*4-1:0] pins);
        logic [3:0] r = '0;
        for (int d = 0; d < NDEV; d++)
            for (int p = 0; p < 4; p++)
                if (pins[d*4+p]) r[(p+d)%4] = 1'b1;
        return r;
    endfunction

    // Downstream responder with random wait states.
    initial begin
        forever begin
            @(negedge clk);
            if (d_ready) begin
                d_ready = 1'b0;
            end else if (d_valid) begin
                if (wait_left == 0) begin
                    cap_we = d_we; cap_addr = d_addr; cap_be = d_be; cap_wdata = d_wdata;
                    d_rdata = $urandom;
                    d_ready = 1'b1;
                    hs_count++;
                    wait_left = $urandom % 4;
                end else begin
                    wait_left--;
                end
            end
        end
    end

    // Interrupt pins toggle independently of the bus traffic (R9).
    initial begin
        @(posedge rst_n);
        while (!done) begin
            @(negedge clk);
            irq_pin = {$urandom, $urandom, $urandom, $urandom} & {4{$urandom}};
            #1;
            check("R9 irq_line", {28'd0, irq_line}, {28'd0, model_irq(irq_pin)});
        end
    end

    task automatic bus(input bit data_win, input bit we, input logic [11:0] off,
                       input logic [1:0] size, input logic [31:0] wd);
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_addr = {data_win, off}; s_size = size; s_wdata = wd;
        do @(negedge clk); while (!s_ack);
        rd_word = s_rdata;
        s_req = 1'b0;
    endtask

    task automatic data_access(input logic [31:0] idx, input string req);
        logic [11:0] off = 12'($urandom);
        logic [1:0]  sz = 2'($urandom);
        bit          we = 1'($urandom);
        logic [31:0] wd = $urandom;
        int          hs0;
        bus(1'b0, 1'b1, 12'h000, 2'd2, idx);
        hs0 = hs_count;
        bus(1'b1, we, off, sz, wd);
        check({req, " addr"}, cap_addr, model_addr(idx, off));
        check("R7 be", {28'd0, cap_be}, {28'd0, model_be(sz, off[1:0])});
        check("R8 we", {31'd0, cap_we}, {31'd0, we});
        check("R8 one request", hs_count - hs0, 1);
        if (we) check("R8 wdata", cap_wdata, wd);
        else    check("R8 rdata", rd_word, d_rdata);
    endtask

    task automatic finish_up;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int hs0;
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 s_ack", {31'd0, s_ack}, 32'd0);
        check("R1 d_valid", {31'd0, d_valid}, 32'd0);
        bus(1'b0, 1'b0, 12'h000, 2'd2, 32'd0);
        check("R1 index", rd_word, 32'd0);

        // R2 byte-enabled index writes, R10 no downstream traffic
        hs0 = hs_count;
        bus(1'b0, 1'b1, 12'h000, 2'd2, 32'hAABB_CCDD);
        bus(1'b0, 1'b1, 12'h001, 2'd0, 32'h0000_1100);
        bus(1'b0, 1'b0, 12'h000, 2'd2, 32'd0);
        check("R2 byte write", rd_word, 32'hAABB_11DD);
        bus(1'b0, 1'b1, 12'hFFE, 2'd1, 32'h7788_0000);
        bus(1'b0, 1'b0, 12'h000, 2'd2, 32'd0);
        check("R2 half write", rd_word, 32'h7788_11DD);
        check("R10 no request", hs_count - hs0, 0);

        // Directed corners
        data_access(32'h0000_0000, "R6");
        data_access(32'h0000_07F8, "R6");
        data_access(32'h4000_0000, "R5");
        data_access(32'h0000_0800, "R5");
        data_access(32'h0001_8300, "R5");
        data_access(32'hFFFF_FFFF, "R3");
        data_access(32'h8000_0000, "R3");
        data_access(32'h7FFF_FFFF, "R4");
        data_access(32'h0000_0001, "R4");

        // Random mix of the three forms
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r = $urandom;
            case ($urandom % 3)
                0: data_access(r | 32'h8000_0000, "R3");
                1: data_access((r & 32'h7FFF_FFFF) | 32'h1, "R4");
                default: begin
                    int sb = 11 + ($urandom % 20);
                    logic [31:0] ix = (r & 32'h7FFF_FFFE & ~((32'd1 << (sb + 1)) - 1))
                                      | (32'd1 << sb) | (r & 32'h7F8);
                    data_access(ix, "R5");
                end
            endcase
        end
        finish_up();
    end
endmodule